// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder/Subtractor

This block adds or subtracts two 16-bit two's-complement operands in a single combinational pass. The operand width is split into four 4-bit slices. Each slice forms per-bit generate (both bits set) and propagate (either bit set) terms. From these it derives its own internal carries in flat sum-of-products form, and it also reports a slice-wide generate and propagate.

A second-level lookahead unit takes the four slice-wide terms and the incoming carry. It produces the carry into every slice and the final carry out directly, so no carry ripples from one slice to the next.

A single mode input selects the operation. With the mode input low, the block forms A plus B. With it high, the B operand is inverted bit by bit, and the mode bit itself becomes the carry into bit 0, so the block forms A minus B. The block reports the sum, the carry out of the top bit, and a signed-overflow flag. Overflow is taken as the exclusive-or of the carry into the top bit and the carry out of it.

Top module: `cla_addsub`

## Requirements
- R1: With `op_sub` = 0, `res_sum` equals (`opd_a` + `opd_b`) mod 2^16, and `res_cout` is bit 16 of the unsigned 17-bit sum.
- R2: With `op_sub` = 1, `res_sum` equals (`opd_a` − `opd_b`) mod 2^16, and `res_cout` is 1 exactly when `opd_a` ≥ `opd_b` as unsigned numbers (no borrow).
- R3: `res_ovf` is 1 exactly when the true signed result of the selected operation lies outside −32768..32767.
- R4: A carry that starts in bit 0 reaches every higher slice through the second-level lookahead. For example, 0xFFFF + 0x0001 gives sum 0x0000 with carry out 1, and 0x0FFF + 0x0001 gives 0x1000.
- R5: The outputs depend only on the present inputs. There is no state, and a new operand set yields its result in the same cycle.
- R6: The most negative value is handled correctly. 0x8000 − 0x0001 gives 0x7FFF with overflow. 0x0000 − 0x8000 gives 0x8000 with overflow. 0x8000 + 0x8000 gives 0x0000 with carry out 1 and overflow.
- R7: Each 4-bit slice reports a slice generate that forces a carry out of the slice whatever its carry in. It also reports a slice propagate that, with a carry in of 1, forces a carry out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a | input | 16 | First operand (minuend when subtracting) |
| opd_b | input | 16 | Second operand (subtrahend when subtracting) |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| res_sum | output | 16 | Sum or difference, modulo 2^16 |
| res_cout | output | 1 | Carry out of bit 15 |
| res_ovf | output | 1 | Signed overflow |

## Verification
The carry-out and overflow flags can be raised by the same operand pair, and they can also disagree. The bench provokes both cases. 0x8000 + 0x8000 sets both flags, 0x7FFF + 0x0001 sets overflow alone, and 0xFFFF + 0x0001 sets carry alone. Each flag is compared separately against a bench model that works from unsigned and signed arithmetic. Random operand pairs in both modes then cover the slice-generate and slice-propagate paths, where a carry must cross several slices in the same evaluation.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned CLA_WIDTH = 16;
  localparam int unsigned CLA_SLICE = 4;
endpackage

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] grp_a,
  input  logic [GW-1:0] grp_b,
  input  logic          grp_cin,
  output logic [GW-1:0] grp_sum,
  output logic          grp_gen,
  output logic          grp_prop,
  output logic          grp_c_msb
);
  logic [GW-1:0] bit_g;
  logic [GW-1:0] bit_p;
  logic [GW:0]   cy;

  assign bit_g = grp_a & grp_b;
  assign bit_p = grp_a | grp_b;

  // flat two-level carries: every carry from g/p terms and cin directly
  always_comb begin
    cy = '0;
    for (int i = 0; i <= GW; i++) begin
      logic run_p;
      logic acc;
      acc   = 1'b0;
      for (int j = 0; j < i; j++) begin
        run_p = bit_g[j];
        for (int k = j + 1; k < i; k++) run_p = run_p & bit_p[k];
        acc = acc | run_p;
      end
      run_p = grp_cin;
      for (int k = 0; k < i; k++) run_p = run_p & bit_p[k];
      cy[i] = acc | run_p;
    end
  end

  always_comb begin
    logic gacc;
    logic term;
    grp_prop = &bit_p;
    gacc = 1'b0;
    for (int j = 0; j < GW; j++) begin
      term = bit_g[j];
      for (int k = j + 1; k < GW; k++) term = term & bit_p[k];
      gacc = gacc | term;
    end
    grp_gen = gacc;
  end

  assign grp_sum   = grp_a ^ grp_b ^ cy[GW-1:0];
  assign grp_c_msb = cy[GW-1];

  // R1 R2: slice arithmetic agrees with a plain add
  always_comb begin
    a_r1_slice_add: assert ({cy[GW], grp_sum} == ({1'b0, grp_a} + {1'b0, grp_b} + {{GW{1'b0}}, grp_cin}))
      else $error("slice sum mismatch");
  end

  // R7: slice generate forces carry out regardless of cin
  always_comb begin
    a_r7_gen_forces: assert (!grp_gen || cy[GW]) else $error("generate without carry");
    a_r7_prop_passes: assert (!(grp_prop && grp_cin) || cy[GW]) else $error("propagate lost carry");
  end
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned NG = 4
) (
  input  logic [NG-1:0] blk_gen,
  input  logic [NG-1:0] blk_prop,
  input  logic          la_cin,
  output logic [NG:0]   la_carry
);
  // second level: carry into each slice from slice terms, no ripple
  always_comb begin
    la_carry = '0;
    for (int i = 0; i <= NG; i++) begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < i; j++) begin
        term = blk_gen[j];
        for (int k = j + 1; k < i; k++) term = term & blk_prop[k];
        acc = acc | term;
      end
      term = la_cin;
      for (int k = 0; k < i; k++) term = term & blk_prop[k];
      la_carry[i] = acc | term;
    end
  end

  // R4: neighbouring carries obey the one-step recurrence
  always_comb begin
    for (int i = 0; i < NG; i++) begin
      a_r4_step: assert (la_carry[i+1] == (blk_gen[i] | (blk_prop[i] & la_carry[i])))
        else $error("lookahead step mismatch");
    end
  end
endmodule

// File: rtl/cla_addsub.sv
module cla_addsub
  import cla_pkg::*;
#(
  parameter int unsigned WIDTH = CLA_WIDTH,
  parameter int unsigned SLICE = CLA_SLICE
) (
  input  logic [WIDTH-1:0] opd_a,
  input  logic [WIDTH-1:0] opd_b,
  input  logic             op_sub,
  output logic [WIDTH-1:0] res_sum,
  output logic             res_cout,
  output logic             res_ovf
);
  localparam int unsigned NSL = WIDTH / SLICE;

  logic [WIDTH-1:0] b_eff;
  logic [NSL-1:0]   s_gen;
  logic [NSL-1:0]   s_prop;
  logic [NSL-1:0]   s_cmsb;
  logic [NSL:0]     s_carry;

  assign b_eff = opd_b ^ {WIDTH{op_sub}};

  cla_lookahead #(.NG(NSL)) u_la (
    .blk_gen (s_gen),
    .blk_prop(s_prop),
    .la_cin  (op_sub),
    .la_carry(s_carry)
  );

  for (genvar g = 0; g < NSL; g++) begin : g_slice
    cla_group #(.GW(SLICE)) u_grp (
      .grp_a    (opd_a[g*SLICE +: SLICE]),
      .grp_b    (b_eff[g*SLICE +: SLICE]),
      .grp_cin  (s_carry[g]),
      .grp_sum  (res_sum[g*SLICE +: SLICE]),
      .grp_gen  (s_gen[g]),
      .grp_prop (s_prop[g]),
      .grp_c_msb(s_cmsb[g])
    );
  end

  assign res_cout = s_carry[NSL];
  assign res_ovf  = s_carry[NSL] ^ s_cmsb[NSL-1];

  // R3: overflow iff like-signed effective operands give an unlike-signed result
  always_comb begin
    a_r3_ovf_sign: assert (res_ovf == ((opd_a[WIDTH-1] == b_eff[WIDTH-1]) && (res_sum[WIDTH-1] != opd_a[WIDTH-1])))
      else $error("overflow flag mismatch");
  end

  // R2: subtract result
  always_comb begin
    a_r2_sub: assert (!op_sub || (res_sum == WIDTH'(opd_a - opd_b)))
      else $error("difference mismatch");
  end
endmodule

// File: tb/cla_addsub_tb.sv
module cla_addsub_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] opd_a;
  logic [15:0] opd_b;
  logic        op_sub;
  logic [15:0] res_sum;
  logic        res_cout;
  logic        res_ovf;
  int          n_vec;
  int          n_bad;
  int          cyc;

  cla_addsub u_dut (
    .opd_a   (opd_a),
    .opd_b   (opd_b),
    .op_sub  (op_sub),
    .res_sum (res_sum),
    .res_cout(res_cout),
    .res_ovf (res_ovf)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [17:0] model(input logic [15:0] a, input logic [15:0] b, input logic s);
    int sa;
    int sb;
    int sr;
    logic [16:0] u;
    logic ov;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (s) begin
      u  = {1'b0, a} + {1'b0, ~b} + 17'd1;
      sr = sa - sb;
    end else begin
      u  = {1'b0, a} + {1'b0, b};
      sr = sa + sb;
    end
    ov = (sr > 32767) || (sr < -32768);
    return {ov, u};
  endfunction

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic s, input string tag);
    logic [17:0] exp;
    @(posedge clk);
    opd_a = a; opd_b = b; op_sub = s;
    @(negedge clk);
    exp = model(a, b, s);
    n_vec++;
    if ({res_ovf, res_cout, res_sum} !== exp) begin
      n_bad++;
      $display("FAIL %s a=%h b=%h sub=%0b got ovf=%0b c=%0b s=%h exp ovf=%0b c=%0b s=%h",
               tag, a, b, s, res_ovf, res_cout, res_sum, exp[17], exp[16], exp[15:0]);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; cyc = 0;
    rst_n = 1'b0;
    opd_a = '0; opd_b = '0; op_sub = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R5 initial/idle state: zero inputs give zero outputs
    apply(16'h0000, 16'h0000, 1'b0, "R5");
    apply(16'h1234, 16'h4321, 1'b0, "R1");
    apply(16'h7FFF, 16'h0001, 1'b0, "R3");
    apply(16'hFFFF, 16'h0001, 1'b0, "R4");
    apply(16'h0FFF, 16'h0001, 1'b0, "R4");
    apply(16'h00FF, 16'h0F01, 1'b0, "R7");
    apply(16'h8000, 16'h8000, 1'b0, "R6");
    apply(16'h8000, 16'h0001, 1'b1, "R6");
    apply(16'h0000, 16'h8000, 1'b1, "R6");
    apply(16'h0005, 16'h0007, 1'b1, "R2");
    apply(16'h0007, 16'h0007, 1'b1, "R2");
    apply(16'hFFFF, 16'hFFFF, 1'b1, "R2");
    apply(16'h0000, 16'h0000, 1'b1, "R2");
    apply(16'h8000, 16'hFFFF, 1'b0, "R3");
    // R5: back-to-back different vectors, each judged in its own cycle
    apply(16'hAAAA, 16'h5555, 1'b0, "R5");
    apply(16'hAAAA, 16'h5555, 1'b1, "R5");
    void'($urandom(32'h00C0FFEE));
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      case (i % 8)
        0: ra = 16'h8000;
        1: rb = 16'hFFFF;
        2: rb = ~ra;
        default: ;
      endcase
      apply(ra, rb, 1'($urandom), (i % 2 == 0) ? "R1" : "R2");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule